// File: doc/BRIEF.md
# Segment Access Fault Classifier

This block sits beside the address unit of a 16-bit segmented processor. For each memory or privilege-sensitive operation it receives one request. The request holds the operating mode, the kind of access, the segment register it names, the offset and operand size, and the cached descriptor fields of that segment. It also receives the current privilege level, the requested privilege of the selector and the I/O privilege level. From these it decides whether the operation may go ahead. If not, it picks the one exception vector that applies.

The verdict is registered. One clock after a request, a single-cycle strobe presents the fault flag and the vector number. While a segment-register load in protected mode is being checked, the block also raises a bus-lock request. This keeps the descriptor-table access indivisible. Fetching descriptors, decoding instructions and dispatching the exception are done elsewhere.

Top module: `seg_fault_check`

## Requirements
- R1: A request with `req_valid` high produces `chk_valid` high on the next clock, for exactly one cycle per request cycle. Reset clears `chk_valid`, `chk_fault` and `chk_vector`.
- R2: In real mode (`prot_mode`=0), a request with `prot_only_op`=1 reports vector 6. This outranks every other fault.
- R3: In real mode, a read (kind 0), write (kind 1) or escape-start (kind 6) operand whose last byte wraps past offset 0xFFFF reports vector 13. Segment loads (2), branches (3), privileged (4) and I/O (5) kinds never fault in real mode.
- R4: The last byte address is offset + size - 1, with a size of 0 taken as 1. A limit check fails when this carries out of bit 15 or exceeds the descriptor limit.
- R5: In protected mode, for kinds 0, 1 and 6, an access-right failure reports vector 13. A read fails on a code segment with the readable bit (`desc_rw`) clear. A write fails on any code segment or on a data segment with `desc_rw` clear. Otherwise a limit failure reports 12 when `seg_sel` is 2 (stack) and 13 for segments 0, 1 and 3.
- R6: An escape data transfer (kind 7) whose operand fails its limit check reports vector 9. In real mode the limit is 0xFFFF.
- R7: A protected-mode segment load (kind 2) passes privilege when max(CPL, RPL) <= DPL. For the stack (`seg_sel`=2) it passes only when RPL = CPL and DPL = CPL. A failure reports 13 ahead of the presence check.
- R8: A protected-mode segment load that passes privilege but has `desc_present`=0 reports vector 11. When the target is the stack, it reports vector 12.
- R9: In protected mode, a privileged operation (kind 4) with CPL not 0 reports 13. An I/O operation (kind 5) with CPL > IOPL reports 13.
- R10: In protected mode, a branch target (kind 3) reports 13 when the descriptor is not a code segment (`desc_code`=0) or the target fails its limit check.
- R11: `lock_req` is high exactly while `req_valid` is high, `prot_mode` is 1 and the kind is a segment load.
- R12: When no fault applies, `chk_fault` is 0 and `chk_vector` is 0. `prot_only_op` has no effect in protected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| prot_only_op | input | 1 | Operation exists only in protected mode |
| acc_kind | input | 3 | 0 read, 1 write, 2 segment load, 3 branch target, 4 privileged, 5 I/O, 6 escape start, 7 escape transfer |
| seg_sel | input | 2 | Segment register targeted; 2 is the stack |
| offset | input | 16 | Operand offset |
| op_size | input | 4 | Operand size in bytes (0 treated as 1) |
| desc_limit | input | 16 | Descriptor limit |
| desc_present | input | 1 | Descriptor present bit |
| desc_code | input | 1 | 1 = code segment, 0 = data segment |
| desc_rw | input | 1 | Readable (code) or writable (data) |
| desc_dpl | input | 2 | Descriptor privilege level |
| cpl | input | 2 | Current privilege level |
| rpl | input | 2 | Selector requested privilege level |
| iopl | input | 2 | I/O privilege level |
| lock_req | output | 1 | Bus lock for the descriptor table access |
| chk_valid | output | 1 | One-cycle result strobe |
| chk_fault | output | 1 | A fault applies |
| chk_vector | output | 8 | Exception vector, 0 when no fault |

## Verification
The bench sweeps offsets and sizes around the 0xFFFF wrap and around the limit. A design that drops the carry or counts the end byte off by one would pass an operand that hangs one byte past the limit, or fault on one that ends exactly on it. It walks every CPL/RPL/DPL combination for each segment register, with the present bit both set and clear. This catches a stack load checked with the data-segment rule, and a not-present fault reported ahead of a privilege fault. Stack and non-stack segments are paired with good and bad access rights. This catches a limit fault sent to the wrong vector, and a stack limit fault given priority over a rights fault. Protected-only operations are run in both modes, which catches vector 6 leaking into protected mode or losing to a wrap fault in real mode.

// File: rtl/seg_chk_pkg.sv
// Shared encodings for the segment access fault classifier.
// Assumes the access kind and segment codes listed in the brief.
package seg_chk_pkg;

    typedef enum logic [2:0] {
        ACC_READ      = 3'd0,
        ACC_WRITE     = 3'd1,
        ACC_SEGLD     = 3'd2,
        ACC_BRANCH    = 3'd3,
        ACC_PRIV      = 3'd4,
        ACC_IO        = 3'd5,
        ACC_ESC_START = 3'd6,
        ACC_ESC_XFER  = 3'd7
    } acc_kind_e;

    localparam logic [1:0] SEG_STACK = 2'd2;

    localparam logic [7:0] VEC_NONE     = 8'd0;
    localparam logic [7:0] VEC_UNDEF    = 8'd6;
    localparam logic [7:0] VEC_ESC_OVR  = 8'd9;
    localparam logic [7:0] VEC_NOT_PRES = 8'd11;
    localparam logic [7:0] VEC_STACK    = 8'd12;
    localparam logic [7:0] VEC_GP       = 8'd13;

    // One flag per fault class; several may be set, the arbiter picks one.
    typedef struct packed {
        logic mode_f;
        logic gp_f;
        logic stack_f;
        logic esc_f;
        logic np_f;
    } fault_set_t;

endpackage

// File: rtl/seg_limit_chk.sv
// Limit checker: works out the last byte touched by an operand and
// compares it with a descriptor limit. Assumes SIZE_W <= OFS_W.
// A size of zero is treated as one byte.
module seg_limit_chk #(
    parameter int OFS_W  = 16,
    parameter int SIZE_W = 4
) (
    input  logic [OFS_W-1:0]  offset,
    input  logic [SIZE_W-1:0] size,
    input  logic [OFS_W-1:0]  limit,
    output logic              wrap,
    output logic              over_limit
);
    localparam int EXT_W = OFS_W + 1;

    logic [SIZE_W-1:0] eff_size;
    logic [EXT_W-1:0]  last_byte;

    // Last byte address with carry kept in the top bit.
    always_comb begin
        eff_size  = (size == '0) ? SIZE_W'(1) : size;
        last_byte = {1'b0, offset}
                  + {{(EXT_W-SIZE_W){1'b0}}, eff_size}
                  - EXT_W'(1);
    end

    // Violation flags: wrap past the top, or beyond the limit.
    always_comb begin
        wrap       = last_byte[OFS_W];
        over_limit = last_byte[OFS_W] || (last_byte[OFS_W-1:0] > limit);
    end
endmodule

// File: rtl/seg_priv_chk.sv
// Privilege comparator: evaluates the segment-load rule (data or stack
// form), the CPL-zero rule and the I/O privilege rule. Levels are
// unsigned, numerically larger meaning less privileged.
module seg_priv_chk #(
    parameter int PL_W = 2
) (
    input  logic            to_stack,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] rpl,
    input  logic [PL_W-1:0] dpl,
    input  logic [PL_W-1:0] iopl,
    output logic            load_ok,
    output logic            priv_ok,
    output logic            io_ok
);
    logic [PL_W-1:0] eff_pl;

    // Weaker of current and requested privilege.
    always_comb eff_pl = (cpl > rpl) ? cpl : rpl;

    // Rule outcomes.
    always_comb begin
        if (to_stack)
            load_ok = (rpl == cpl) && (dpl == cpl);
        else
            load_ok = (eff_pl <= dpl);
        priv_ok = (cpl == '0);
        io_ok   = (cpl <= iopl);
    end
endmodule

// File: rtl/seg_fault_prio.sv
// Fault arbiter: reduces a set of fault flags to a single vector.
// Order: mode, general protection, stack, escape overrun, not present.
module seg_fault_prio
    import seg_chk_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  fault_set_t       flags,
    output logic             any_fault,
    output logic [VEC_W-1:0] vector
);
    // Fixed-priority selection.
    always_comb begin
        any_fault = 1'b1;
        if (flags.mode_f)       vector = VEC_W'(VEC_UNDEF);
        else if (flags.gp_f)    vector = VEC_W'(VEC_GP);
        else if (flags.stack_f) vector = VEC_W'(VEC_STACK);
        else if (flags.esc_f)   vector = VEC_W'(VEC_ESC_OVR);
        else if (flags.np_f)    vector = VEC_W'(VEC_NOT_PRES);
        else begin
            any_fault = 1'b0;
            vector    = VEC_W'(VEC_NONE);
        end
    end
endmodule

// File: rtl/seg_fault_check.sv
// Top of the segment access fault classifier. Classifies one request
// per cycle into fault flags, arbitrates to a single vector and
// registers the verdict with a one-cycle strobe. Assumes descriptor
// fields are already cached and valid alongside the request.
module seg_fault_check
    import seg_chk_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int SIZE_W = 4,
    parameter int PL_W   = 2,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              prot_mode,
    input  logic              prot_only_op,
    input  logic [2:0]        acc_kind,
    input  logic [1:0]        seg_sel,
    input  logic [OFS_W-1:0]  offset,
    input  logic [SIZE_W-1:0] op_size,
    input  logic [OFS_W-1:0]  desc_limit,
    input  logic              desc_present,
    input  logic              desc_code,
    input  logic              desc_rw,
    input  logic [PL_W-1:0]   desc_dpl,
    input  logic [PL_W-1:0]   cpl,
    input  logic [PL_W-1:0]   rpl,
    input  logic [PL_W-1:0]   iopl,
    output logic              lock_req,
    output logic              chk_valid,
    output logic              chk_fault,
    output logic [VEC_W-1:0]  chk_vector
);
    acc_kind_e  kind;
    logic       to_stack;
    logic       wrap, over_limit;
    logic       load_ok, priv_ok, io_ok;
    logic       rights_bad;
    fault_set_t flags;
    logic       any_fault;
    logic [VEC_W-1:0] vec_next;

    // Decode the kind and the stack target.
    always_comb begin
        kind     = acc_kind_e'(acc_kind);
        to_stack = (seg_sel == SEG_STACK);
    end

    seg_limit_chk #(
        .OFS_W (OFS_W),
        .SIZE_W(SIZE_W)
    ) u_limit (
        .offset    (offset),
        .size      (op_size),
        .limit     (desc_limit),
        .wrap      (wrap),
        .over_limit(over_limit)
    );

    seg_priv_chk #(
        .PL_W(PL_W)
    ) u_priv (
        .to_stack(to_stack),
        .cpl     (cpl),
        .rpl     (rpl),
        .dpl     (desc_dpl),
        .iopl    (iopl),
        .load_ok (load_ok),
        .priv_ok (priv_ok),
        .io_ok   (io_ok)
    );

    // Access-right failure for data-style accesses.
    always_comb begin
        case (kind)
            ACC_WRITE: rights_bad = desc_code || !desc_rw;
            default:   rights_bad = desc_code && !desc_rw;
        endcase
    end

    // Classify the request into fault flags.
    always_comb begin
        flags = '0;
        if (!prot_mode) begin
            flags.mode_f = prot_only_op;
            case (kind)
                ACC_READ, ACC_WRITE, ACC_ESC_START: flags.gp_f  = wrap;
                ACC_ESC_XFER:                       flags.esc_f = wrap;
                default: ;
            endcase
        end else begin
            case (kind)
                ACC_READ, ACC_WRITE, ACC_ESC_START: begin
                    flags.gp_f    = rights_bad || (over_limit && !to_stack);
                    flags.stack_f = over_limit && to_stack;
                end
                ACC_ESC_XFER: flags.esc_f = over_limit;
                ACC_SEGLD: begin
                    flags.gp_f    = !load_ok;
                    flags.stack_f = !desc_present && to_stack;
                    flags.np_f    = !desc_present && !to_stack;
                end
                ACC_BRANCH: flags.gp_f = !desc_code || over_limit;
                ACC_PRIV:   flags.gp_f = !priv_ok;
                ACC_IO:     flags.gp_f = !io_ok;
                default: ;
            endcase
        end
    end

    seg_fault_prio #(
        .VEC_W(VEC_W)
    ) u_prio (
        .flags    (flags),
        .any_fault(any_fault),
        .vector   (vec_next)
    );

    // Lock the bus while a descriptor table entry is consulted.
    always_comb lock_req = req_valid && prot_mode && (kind == ACC_SEGLD);

    // Register the verdict and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_valid  <= 1'b0;
            chk_fault  <= 1'b0;
            chk_vector <= '0;
        end else begin
            chk_valid <= req_valid;
            if (req_valid) begin
                chk_fault  <= any_fault;
                chk_vector <= vec_next;
            end
        end
    end
endmodule

// File: rtl/seg_fault_check_sva.sv
// Property checker for seg_fault_check, attached through bind.
// Observes ports only.
module seg_fault_check_sva #(
    parameter int OFS_W  = 16,
    parameter int SIZE_W = 4,
    parameter int PL_W   = 2,
    parameter int VEC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              prot_mode,
    input logic              prot_only_op,
    input logic [2:0]        acc_kind,
    input logic [1:0]        seg_sel,
    input logic [OFS_W-1:0]  offset,
    input logic [SIZE_W-1:0] op_size,
    input logic [PL_W-1:0]   cpl,
    input logic              lock_req,
    input logic              chk_valid,
    input logic              chk_fault,
    input logic [VEC_W-1:0]  chk_vector
);
    p_strobe_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> chk_valid);

    p_strobe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !chk_valid);

    p_mode_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_mode && prot_only_op)
        |=> (chk_fault && chk_vector == VEC_W'(6)));

    p_real_word_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_mode && !prot_only_op && acc_kind == 3'd0
         && offset == '1 && op_size == SIZE_W'(2))
        |=> (chk_vector == VEC_W'(13)));

    p_not_present_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_vector == VEC_W'(11))
        |-> ($past(acc_kind) == 3'd2 && $past(seg_sel) != 2'd2 && $past(prot_mode)));

    p_priv_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_mode && acc_kind == 3'd4 && cpl != '0)
        |=> (chk_vector == VEC_W'(13)));

    p_lock_scope_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |-> (req_valid && prot_mode && acc_kind == 3'd2));

    p_clean_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_fault) |-> (chk_vector == '0));
endmodule

bind seg_fault_check seg_fault_check_sva #(
    .OFS_W (OFS_W),
    .SIZE_W(SIZE_W),
    .PL_W  (PL_W),
    .VEC_W (VEC_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .prot_mode   (prot_mode),
    .prot_only_op(prot_only_op),
    .acc_kind    (acc_kind),
    .seg_sel     (seg_sel),
    .offset      (offset),
    .op_size     (op_size),
    .cpl         (cpl),
    .lock_req    (lock_req),
    .chk_valid   (chk_valid),
    .chk_fault   (chk_fault),
    .chk_vector  (chk_vector)
);

// File: tb/seg_fault_check_test.sv
// Sweep bench for seg_fault_check with an arithmetic reference model.
module seg_fault_check_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        prot_mode = 1'b0;
    logic        prot_only_op = 1'b0;
    logic [2:0]  acc_kind = '0;
    logic [1:0]  seg_sel = '0;
    logic [15:0] offset = '0;
    logic [3:0]  op_size = '0;
    logic [15:0] desc_limit = '0;
    logic        desc_present = 1'b0;
    logic        desc_code = 1'b0;
    logic        desc_rw = 1'b0;
    logic [1:0]  desc_dpl = '0;
    logic [1:0]  cpl = '0;
    logic [1:0]  rpl = '0;
    logic [1:0]  iopl = '0;
    logic        lock_req, chk_valid, chk_fault;
    logic [7:0]  chk_vector;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    seg_fault_check uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_mode(prot_mode),
        .prot_only_op(prot_only_op), .acc_kind(acc_kind), .seg_sel(seg_sel),
        .offset(offset), .op_size(op_size), .desc_limit(desc_limit),
        .desc_present(desc_present), .desc_code(desc_code), .desc_rw(desc_rw),
        .desc_dpl(desc_dpl), .cpl(cpl), .rpl(rpl), .iopl(iopl),
        .lock_req(lock_req), .chk_valid(chk_valid), .chk_fault(chk_fault),
        .chk_vector(chk_vector)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (kind %0d seg %0d off %h size %0d lim %h prot %0d)",
                     req, act, exp, acc_kind, seg_sel, offset, op_size, desc_limit, prot_mode);
        end
    endtask

    // Reference vector from the requirements.
    function automatic int model();
        int sz, last;
        bit carry, lf, bad, ok;
        sz    = (op_size == 0) ? 1 : int'(op_size);
        last  = int'(offset) + sz - 1;
        carry = last > 65535;
        lf    = carry || (last > int'(desc_limit));             // R4
        if (!prot_mode) begin
            if (prot_only_op) return 6;                         // R2
            if (acc_kind inside {3'd0, 3'd1, 3'd6} && carry) return 13; // R3
            if (acc_kind == 3'd7 && carry) return 9;            // R6
            return 0;
        end
        case (acc_kind)
            3'd0, 3'd1, 3'd6: begin                             // R5
                bad = (acc_kind == 3'd1) ? (desc_code || !desc_rw) : (desc_code && !desc_rw);
                if (bad) return 13;
                if (lf) return (seg_sel == 2) ? 12 : 13;
                return 0;
            end
            3'd7: return lf ? 9 : 0;
            3'd2: begin                                         // R7, R8
                if (seg_sel == 2) ok = (rpl == cpl) && (desc_dpl == cpl);
                else ok = (((cpl > rpl) ? cpl : rpl) <= desc_dpl);
                if (!ok) return 13;
                if (!desc_present) return (seg_sel == 2) ? 12 : 11;
                return 0;
            end
            3'd3: return (!desc_code || lf) ? 13 : 0;           // R10
            3'd4: return (cpl != 0) ? 13 : 0;                   // R9
            default: return (cpl > iopl) ? 13 : 0;              // R9
        endcase
    endfunction

    function automatic string tag();
        if (!prot_mode) return (prot_only_op ? "R2" : (acc_kind == 7 ? "R6" : "R3"));
        case (acc_kind)
            3'd0, 3'd1, 3'd6: return "R5/R4";
            3'd7: return "R6";
            3'd2: return "R7/R8";
            3'd3: return "R10";
            default: return "R9";
        endcase
    endfunction

    // Present the current inputs for one cycle and check the results.
    task automatic apply();
        int exp_v;
        exp_v = model();
        req_valid = 1'b1;
        #1;
        check("R11 lock_req", int'(lock_req), int'(prot_mode && acc_kind == 3'd2));
        @(negedge clk);
        check("R1 chk_valid", int'(chk_valid), 1);
        check(tag(), int'(chk_vector), exp_v);
        check("R12 chk_fault", int'(chk_fault), int'(exp_v != 0));
    endtask

    initial begin : watchdog
        #700000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(chk_valid), 0);
        check("R1 reset fault", int'(chk_fault), 0);
        check("R1 reset vector", int'(chk_vector), 0);
        rst_n = 1'b1;

        // Real mode: all kinds, around the wrap point.
        prot_mode = 1'b0;
        desc_limit = 16'h0010;
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < 8; k++)
                for (int o = 0; o < 5; o++)
                    for (int s = 0; s < 4; s++) begin
                        prot_only_op = p[0];
                        acc_kind = 3'(k);
                        offset = (o == 0) ? 16'h0000 : (o == 1) ? 16'h0001 :
                                 (o == 2) ? 16'hFFFE : (o == 3) ? 16'hFFFF : 16'h8000;
                        op_size = 4'(s);
                        apply();
                    end

        // Protected mode data-style accesses.
        prot_mode = 1'b1;
        for (int k = 0; k < 4; k++)
            for (int sg = 0; sg < 4; sg++)
                for (int t = 0; t < 4; t++)
                    for (int l = 0; l < 4; l++)
                        for (int o = 0; o < 5; o++)
                            for (int s = 0; s < 4; s++) begin
                                acc_kind = (k == 0) ? 3'd0 : (k == 1) ? 3'd1 : (k == 2) ? 3'd6 : 3'd7;
                                seg_sel = 2'(sg);
                                desc_code = t[1];
                                desc_rw = t[0];
                                prot_only_op = t[0] ^ s[0];   // R12: no effect here
                                desc_limit = (l == 0) ? 16'h0000 : (l == 1) ? 16'h0007 :
                                             (l == 2) ? 16'hFFFE : 16'hFFFF;
                                offset = (o == 0) ? 16'h0000 : (o == 1) ? 16'h0006 :
                                         (o == 2) ? 16'h0007 : (o == 3) ? 16'hFFFE : 16'hFFFF;
                                op_size = 4'(s);
                                apply();
                            end

        // Segment loads: full privilege sweep with present set and clear.
        acc_kind = 3'd2;
        for (int sg = 0; sg < 4; sg++)
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    for (int d = 0; d < 4; d++)
                        for (int pr = 0; pr < 2; pr++) begin
                            seg_sel = 2'(sg);
                            cpl = 2'(c);
                            rpl = 2'(r);
                            desc_dpl = 2'(d);
                            desc_present = pr[0];
                            prot_only_op = pr[0];
                            apply();
                        end

        // Privileged and I/O operations.
        for (int k = 4; k < 6; k++)
            for (int c = 0; c < 4; c++)
                for (int i = 0; i < 4; i++) begin
                    acc_kind = 3'(k);
                    cpl = 2'(c);
                    iopl = 2'(i);
                    apply();
                end

        // Branch targets.
        acc_kind = 3'd3;
        op_size = 4'd1;
        for (int t = 0; t < 2; t++)
            for (int l = 0; l < 4; l++)
                for (int o = 0; o < 5; o++) begin
                    desc_code = t[0];
                    desc_limit = (l == 0) ? 16'h0000 : (l == 1) ? 16'h0007 :
                                 (l == 2) ? 16'hFFFE : 16'hFFFF;
                    offset = (o == 0) ? 16'h0000 : (o == 1) ? 16'h0007 :
                             (o == 2) ? 16'h0008 : (o == 3) ? 16'hFFFE : 16'hFFFF;
                    apply();
                end

        // Strobe drops when no request follows.
        req_valid = 1'b0;
        #1;
        check("R11 lock idle", int'(lock_req), 0);
        @(negedge clk);
        check("R1 strobe idle", int'(chk_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule